// File: doc/BRIEF.md
# I2C Register-Write Target

This block is an I2C target that holds a small bank of 16-bit registers and lets a bus master load them. The system clock samples SCL and SDA through a synchroniser. The block finds start and stop conditions, shifts in bytes on SCL rising edges, and pulls SDA low for acknowledge through an output-enable that feeds an external open-drain driver. Every register in the bank drives the outputs at all times.

A transaction opens with a start, followed by the 7-bit target address and a write bit of 0. Each register update after that is three bytes: a pointer, then the upper data byte, then the lower data byte. When the lower byte has been acknowledged, the next byte is read as a fresh pointer. A master can therefore fill several registers, such as the command register at pointer 0 and one other, before it sends the stop. The block has no data stream, so there is no valid/ready handshake. SCL and SDA follow the bus timing and no back-pressure exists, because the target never holds SCL low.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset every register reads 0 and `sda_oe` is low.
- R2: An address byte whose upper seven bits equal `TGT_ADDR` and whose bit 0 is 0 is acknowledged. The target drives SDA low through the ninth SCL pulse.
- R3: An address byte that does not match, or that has bit 0 equal to 1, is not acknowledged. Every byte after it is also left unacknowledged and changes no register, until the next start.
- R4: In a matched transaction the register selected by the pointer byte takes the value {upper byte, lower byte}, and all three bytes are acknowledged.
- R5: After each lower data byte the next byte is a new pointer. One transaction can write pointer 0 and other registers in sequence.
- R6: A register changes only after its lower byte has been acknowledged. A stop that arrives after the upper byte alone leaves every register unchanged.
- R7: A start inside a transaction (repeated start) returns the framing to the address phase and drops any partial register write.
- R8: A pointer at or above `NREG` is acknowledged together with its two data bytes, but no register changes.
- R9: The target asserts `sda_oe` only after an SCL falling edge and never while the master is sending a data bit. It releases `sda_oe` after the falling edge that ends the acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, the open-drain driver pulls SDA low |
| regs_o | output | NREG*16 | Register bank; register k sits in bits [16k+15:16k] |

## Verification
Several rules are checked by assertions on every cycle. The acknowledge drive starts only after an SCL fall and stays off while the target is idle. A register write happens only in the cycle after an acknowledge has ended, and lasts one cycle. The bank holds its value when no write occurs or when the pointer is out of range. Only the bench scenarios can show the whole framing. Those scenarios cover the address match and rejection, multiple pointer/upper/lower triplets in one transaction, a partial write cut off by a stop, a repeated start in the middle of a frame, and the values that end up in the registers.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_HI,
    PH_LO
  } phase_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else if (g == 0) begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end else begin
          scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
          sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_frame.sv
module i2cw_frame
  import i2cw_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_ptr,
  output logic [REG_W-1:0]  wr_data
);
  localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

  phase_t            phase;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] hi_byte;
  logic              in_ack;
  logic              commit_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      hi_byte     <= '0;
      in_ack      <= 1'b0;
      commit_pend <= 1'b0;
      sda_oe      <= 1'b0;
      wr_en       <= 1'b0;
      wr_ptr      <= '0;
      wr_data     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det || stop_det) begin
        phase       <= start_det ? PH_ADDR : PH_IDLE;
        bitcnt      <= '0;
        in_ack      <= 1'b0;
        commit_pend <= 1'b0;
        sda_oe      <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !in_ack && bitcnt < BITS_FULL) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && in_ack) begin
          in_ack <= 1'b0;
          sda_oe <= 1'b0;
          bitcnt <= '0;
          if (commit_pend) begin
            wr_en       <= 1'b1;
            commit_pend <= 1'b0;
          end
        end else if (scl_fall && bitcnt == BITS_FULL) begin
          in_ack <= 1'b1;
          sda_oe <= 1'b1;
          case (phase)
            PH_ADDR: begin
              if (shreg[BYTE_W-1:1] == TGT_ADDR && !shreg[0]) begin
                phase <= PH_PTR;
              end else begin
                phase  <= PH_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
              end
            end
            PH_PTR: begin
              wr_ptr <= shreg;
              phase  <= PH_HI;
            end
            PH_HI: begin
              hi_byte <= shreg;
              phase   <= PH_LO;
            end
            PH_LO: begin
              wr_data     <= {hi_byte, shreg};
              commit_pend <= 1'b1;
              phase       <= PH_PTR;
            end
            default: begin
              phase  <= PH_IDLE;
              in_ack <= 1'b0;
              sda_oe <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  // R9
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !sda_oe);

  // R6
  commit_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(sda_oe));

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank
  import i2cw_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     wr_idx,
  input  logic [REG_W-1:0]      wr_data,
  output logic [NREG*REG_W-1:0] regs_o
);
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic [REG_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)                                 r <= '0;
        else if (wr_en && wr_idx == BYTE_W'(g))  r <= wr_data;
      end
      assign regs_o[g*REG_W +: REG_W] = r;
    end
  endgenerate

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_o));

  // R8
  oor_nochange_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= BYTE_W'(NREG)) |=> $stable(regs_o));
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
  import i2cw_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h2C,
  parameter int         NREG        = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NREG*REG_W-1:0] regs_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_ptr;
  logic [REG_W-1:0]  wr_data;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cw_frame #(.TGT_ADDR(TGT_ADDR)) u_frame (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data)
  );

  i2cw_regbank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_ptr),
    .wr_data(wr_data), .regs_o(regs_o)
  );
endmodule

// File: tb/tb_i2c_regwr_target.sv
module tb_i2c_regwr_target;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int NREG = 4;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [NREG*16-1:0] regs_o;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  int acks;
  bit done = 0;
  bit early_oe = 0;
  logic [15:0] model [NREG];

  always #2 clk = ~clk;

  i2c_regwr_target #(.TGT_ADDR(ADDR), .NREG(NREG)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  // {pointer, data}
  localparam logic [23:0] VEC [0:7] = '{
    24'h01A55A, 24'h000001, 24'h03FFFF, 24'h028001,
    24'h071234, 24'h010000, 24'h0300FF, 24'hFFDEAD
  };

  task automatic hw(int n = HALF);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    for (int k = 0; k < NREG; k++) chk(tag, 64'(regs_o[k*16 +: 16]), 64'(model[k]));
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; scl = 1'b1; hw();
    m_sda = 1'b0; hw();
    scl = 1'b0; hw();
  endtask

  task automatic i2c_rstart();
    m_sda = 1'b1; hw();
    scl = 1'b1; hw();
    m_sda = 1'b0; hw();
    scl = 1'b0; hw();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hw();
    scl = 1'b1; hw();
    m_sda = 1'b1; hw();
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw();
      scl = 1'b1; hw();
      if (sda_oe) early_oe = 1;
      scl = 1'b0;
    end
    m_sda = 1'b1; hw();
    scl = 1'b1; hw(HALF/2);
    if (!sda_line) acks++;
    hw(HALF/2);
    scl = 1'b0; hw(HALF/2);
    if (sda_oe) early_oe = 1;
  endtask

  task automatic write_tx(logic [7:0] p, logic [15:0] d);
    acks = 0;
    i2c_start();
    send_byte({ADDR, 1'b0});
    send_byte(p);
    send_byte(d[15:8]);
    send_byte(d[7:0]);
    i2c_stop();
    hw(8);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hw(5);
    // R1 reset state
    check_regs("R1 reset regs");
    chk("R1 reset sda_oe", 64'(sda_oe), 64'd0);

    // Vector walk: R2, R4, R8
    for (int v = 0; v < 8; v++) begin
      write_tx(VEC[v][23:16], VEC[v][15:0]);
      if (VEC[v][23:16] < NREG) model[VEC[v][23:16]] = VEC[v][15:0];
      chk("R2/R4/R8 ack count", 64'(acks), 64'd4);
      check_regs("R4/R8 regs after write");
    end

    // R3 wrong address
    acks = 0;
    i2c_start();
    send_byte({ADDR ^ 7'h01, 1'b0});
    send_byte(8'h01); send_byte(8'h55); send_byte(8'h66);
    i2c_stop(); hw(8);
    chk("R3 wrong address acks", 64'(acks), 64'd0);
    check_regs("R3 wrong address regs");

    // R3 read bit set
    acks = 0;
    i2c_start();
    send_byte({ADDR, 1'b1});
    send_byte(8'h02); send_byte(8'h77); send_byte(8'h88);
    i2c_stop(); hw(8);
    chk("R3 read bit acks", 64'(acks), 64'd0);
    check_regs("R3 read bit regs");

    // R5 multi-register: command register 0 then register 2
    acks = 0;
    i2c_start();
    send_byte({ADDR, 1'b0});
    send_byte(8'h00); send_byte(8'h0F); send_byte(8'h0F);
    send_byte(8'h02); send_byte(8'h13); send_byte(8'h57);
    i2c_stop(); hw(8);
    model[0] = 16'h0F0F; model[2] = 16'h1357;
    chk("R5 multi acks", 64'(acks), 64'd7);
    check_regs("R5 multi regs");

    // R6 stop after upper byte discards
    acks = 0;
    i2c_start();
    send_byte({ADDR, 1'b0});
    send_byte(8'h01); send_byte(8'hEE);
    check_regs("R6 no update after upper byte");
    i2c_stop(); hw(8);
    chk("R6 partial acks", 64'(acks), 64'd3);
    check_regs("R6 partial regs");

    // R7 repeated start mid-frame
    acks = 0;
    i2c_start();
    send_byte({ADDR, 1'b0});
    send_byte(8'h03); send_byte(8'h12);
    i2c_rstart();
    send_byte({ADDR, 1'b0});
    send_byte(8'h03); send_byte(8'hAB); send_byte(8'hCD);
    i2c_stop(); hw(8);
    model[3] = 16'hABCD;
    chk("R7 repeated start acks", 64'(acks), 64'd7);
    check_regs("R7 repeated start regs");

    // R9 ack drive timing across the whole run
    chk("R9 sda_oe outside ack bit", 64'(early_oe), 64'd0);
    chk("R9 sda_oe idle at end", 64'(sda_oe), 64'd0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule